// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block is a real-time clock peripheral that runs directly on a slow crystal tick of about 33.33 kHz. Every clock cycle is one crystal tick. A trimmable divider counts ticks up to a programmed limit and produces a one-second step. An optional fractional trim lengthens some seconds by one extra tick so that the average period can be set more finely than a whole tick. The step advances a 32-bit seconds counter. That counter can be loaded at any time and is compared against an alarm value.

Software reaches the block over a plain 32-bit register bus. Writes take effect on the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. There are two interrupt sources, a per-second event and an alarm match. Each source has a status bit that is cleared by writing 1, and a mask bit that is changed through separate unmask and mask registers, so no read-modify-write is needed. Each interrupt output is a level signal.

Top module: `secrtc_top`

## Requirements
- R1: After reset the calibration readback (0x0C) is 0x198233, the mask (0x24) is 0x3, the status (0x20) is 0, the control (0x40) is 0x01000000, the seconds readout (0x10) is 0, and both interrupt outputs are low.
- R2: A write to 0x00 loads the seconds counter and is returned at 0x04. It also zeroes the tick counter and the fractional phase, so the next second is a full period starting from that edge.
- R3: With bit 20 of the calibration clear, every second lasts L+1 cycles, where L is calibration bits 15:0. Offset 0x14 returns the live tick count in bits 15:0.
- R4: With calibration bit 20 set, second number p (counted from 0 after a set-time write, modulo 16) lasts one extra cycle when p is less than F, the value in calibration bits 19:16. Each 16-second window therefore holds exactly F stretched seconds.
- R5: The seconds counter wraps from 0xFFFFFFFF to 0.
- R6: Status bit 0 is set on the edge where the seconds counter steps. Writing 1 to that bit at 0x20 clears it, and writing 0 leaves it unchanged.
- R7: Status bit 1 is set one cycle after the seconds count becomes equal to the alarm register (0x18). It is set once per match and does not set again while the values stay equal.
- R8: Writing 1 to bit n at 0x28 clears mask bit n, and writing 1 at 0x2C sets it. Mask bit n reads back at 0x24. `irq_sec` and `irq_alarm` each equal their status bit AND NOT their mask bit.
- R9: Control bit 24 (0x40) enables the oscillator. While it is 0, the tick counter and the seconds counter hold their values.
- R10: A calibration write to 0x08 keeps bits 20:0 of the write data. The stored value reads back at 0x0C with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_sec | output | 1 | Per-second interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
A write on edge E changes its register, the tick counter and the mask on that same edge, so those results are read at the falling edge just after E. With limit L and no stretch, the seconds step lands on edge E+L+1, and the per-second status bit sets on that same edge. The alarm status bit sets one edge after the seconds value reaches the alarm. Every directed task starts its cycle count from the set-time write and samples on falling edges, one cycle before and one cycle after each predicted step. Fractional checks add up the per-second periods over a full 16-second window and into the next one.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int TICK_W  = 16;
  localparam int FRAC_W  = 4;
  localparam int CAL_W   = TICK_W + FRAC_W + 1;
  localparam int LIM_W   = TICK_W + 1;
  localparam int NSRC    = 2;
  localparam int OSC_BIT = 24;

  localparam logic [ADDR_W-1:0] A_TIME_LOAD = 8'h00;
  localparam logic [ADDR_W-1:0] A_TIME_ECHO = 8'h04;
  localparam logic [ADDR_W-1:0] A_TRIM_WR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_TRIM_RD   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_NOW_SEC   = 8'h10;
  localparam logic [ADDR_W-1:0] A_NOW_TICK  = 8'h14;
  localparam logic [ADDR_W-1:0] A_WAKE_AT   = 8'h18;
  localparam logic [ADDR_W-1:0] A_EVT_FLAGS = 8'h20;
  localparam logic [ADDR_W-1:0] A_EVT_MASK  = 8'h24;
  localparam logic [ADDR_W-1:0] A_EVT_UNMSK = 8'h28;
  localparam logic [ADDR_W-1:0] A_EVT_SETMSK= 8'h2C;
  localparam logic [ADDR_W-1:0] A_CONTROL   = 8'h40;

  typedef struct packed {
    logic              trim_on;
    logic [FRAC_W-1:0] trim_frac;
    logic [TICK_W-1:0] tick_max;
  } trim_t;

  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;

  // True when the second at phase ph gets one extra tick.
  function automatic logic stretch_now(trim_t c, logic [FRAC_W-1:0] ph);
    return c.trim_on && (ph < c.trim_frac);
  endfunction

  // Last tick value of the current second.
  function automatic logic [LIM_W-1:0] second_limit(trim_t c, logic [FRAC_W-1:0] ph);
    return {1'b0, c.tick_max} + LIM_W'(stretch_now(c, ph));
  endfunction
endpackage

// File: rtl/secrtc_divider.sv
module secrtc_divider
  import secrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  trim_t             trim,
  output logic [TICK_W-1:0] tick_o,
  output logic              wrap_o
);
  logic [LIM_W-1:0]  tick_q;
  logic [FRAC_W-1:0] phase_q;
  logic [LIM_W-1:0]  limit;
  logic              at_end;

  assign limit  = second_limit(trim, phase_q);
  assign at_end = (tick_q >= limit);
  assign wrap_o = run & ~restart & at_end;
  assign tick_o = tick_q[TICK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      phase_q <= '0;
    end else if (restart) begin
      tick_q  <= '0;
      phase_q <= '0;
    end else if (run) begin
      if (at_end) begin
        tick_q  <= '0;
        phase_q <= phase_q + FRAC_W'(1);
      end else begin
        tick_q  <= tick_q + LIM_W'(1);
      end
    end
  end

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (tick_q == '0));
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick_q == '0) && (phase_q == '0));
  p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(tick_q) && $stable(phase_q));
endmodule

// File: rtl/secrtc_timekeep.sv
module secrtc_timekeep
  import secrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  input  logic [DATA_W-1:0] alarm_val,
  output logic [DATA_W-1:0] secs_o,
  output logic              alarm_evt_o
);
  logic [DATA_W-1:0] secs_q;
  logic              match_q;
  logic              match_now;

  assign match_now   = (secs_q == alarm_val);
  assign alarm_evt_o = match_now & ~match_q;
  assign secs_o      = secs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      match_q <= 1'b1;
    end else begin
      match_q <= match_now;
      if (load)      secs_q <= load_val;
      else if (step) secs_q <= secs_q + DATA_W'(1);
    end
  end

  p_step_plus1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (secs_q == $past(secs_q) + DATA_W'(1)));
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (secs_q == $past(load_val)));
  p_alarm_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt_o |=> !alarm_evt_o);
endmodule

// File: rtl/secrtc_irq.sv
module secrtc_irq
  import secrtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr,
  input  logic            unmask_wr,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] irq_o
);
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[g] <= 1'b0;
        mask_q[g]   <= 1'b1;
      end else begin
        status_q[g] <= evt[g] | (status_q[g] & ~(clr_wr & wbits[g]));
        if (unmask_wr && wbits[g])    mask_q[g] <= 1'b0;
        else if (mask_wr && wbits[g]) mask_q[g] <= 1'b1;
      end
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = status_q & ~mask_q;

  p_sec_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_SEC] |=> status_q[SRC_SEC]);
  p_alarm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_ALARM] |=> status_q[SRC_ALARM]);
  p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_wr && wbits[SRC_SEC]) |=> !mask_q[SRC_SEC]);
  p_setmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && wbits[SRC_ALARM]) |=> mask_q[SRC_ALARM]);
endmodule

// File: rtl/secrtc_regs.sv
module secrtc_regs
  import secrtc_pkg::*;
#(
  parameter logic [CAL_W-1:0] TRIM_RESET = 21'h198233
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] secs,
  input  logic [TICK_W-1:0] tick,
  input  logic [NSRC-1:0]   status,
  input  logic [NSRC-1:0]   mask,
  output trim_t             trim,
  output logic [DATA_W-1:0] alarm_val,
  output logic              osc_en,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic              clr_wr,
  output logic              unmask_wr,
  output logic              mask_wr,
  output logic [NSRC-1:0]   wbits
);
  logic [DATA_W-1:0] echo_q;
  logic [CAL_W-1:0]  trim_q;
  logic [DATA_W-1:0] alarm_q;
  logic              osc_q;
  logic              trim_wr;
  logic              alarm_wr;
  logic              ctrl_wr;

  assign load      = bus_wr && (bus_addr == A_TIME_LOAD);
  assign trim_wr   = bus_wr && (bus_addr == A_TRIM_WR);
  assign alarm_wr  = bus_wr && (bus_addr == A_WAKE_AT);
  assign ctrl_wr   = bus_wr && (bus_addr == A_CONTROL);
  assign clr_wr    = bus_wr && (bus_addr == A_EVT_FLAGS);
  assign unmask_wr = bus_wr && (bus_addr == A_EVT_UNMSK);
  assign mask_wr   = bus_wr && (bus_addr == A_EVT_SETMSK);
  assign wbits     = bus_wdata[NSRC-1:0];
  assign load_val  = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q  <= '0;
      trim_q  <= TRIM_RESET;
      alarm_q <= '0;
      osc_q   <= 1'b1;
    end else begin
      if (load)     echo_q  <= bus_wdata;
      if (trim_wr)  trim_q  <= bus_wdata[CAL_W-1:0];
      if (alarm_wr) alarm_q <= bus_wdata;
      if (ctrl_wr)  osc_q   <= bus_wdata[OSC_BIT];
    end
  end

  assign trim      = trim_t'(trim_q);
  assign alarm_val = alarm_q;
  assign osc_en    = osc_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TIME_ECHO: bus_rdata = echo_q;
      A_TRIM_RD:   bus_rdata = DATA_W'(trim_q);
      A_NOW_SEC:   bus_rdata = secs;
      A_NOW_TICK:  bus_rdata = DATA_W'(tick);
      A_WAKE_AT:   bus_rdata = alarm_q;
      A_EVT_FLAGS: bus_rdata = DATA_W'(status);
      A_EVT_MASK:  bus_rdata = DATA_W'(mask);
      A_CONTROL:   bus_rdata[OSC_BIT] = osc_q;
      default:     bus_rdata = '0;
    endcase
  end

  p_trim_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trim_wr |=> (trim_q == $past(bus_wdata[CAL_W-1:0])));
endmodule

// File: rtl/secrtc_top.sv
module secrtc_top
  import secrtc_pkg::*;
#(
  parameter logic [CAL_W-1:0] TRIM_RESET = 21'h198233
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  trim_t             trim;
  logic [DATA_W-1:0] alarm_val;
  logic              osc_en;
  logic              load;
  logic [DATA_W-1:0] load_val;
  logic              clr_wr;
  logic              unmask_wr;
  logic              mask_wr;
  logic [NSRC-1:0]   wbits;
  logic [DATA_W-1:0] secs;
  logic [TICK_W-1:0] tick;
  logic              sec_step;
  logic              alarm_evt;
  logic [NSRC-1:0]   evt;
  logic [NSRC-1:0]   status;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   irq_vec;

  secrtc_regs #(.TRIM_RESET(TRIM_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .secs(secs), .tick(tick),
    .status(status), .mask(mask), .trim(trim), .alarm_val(alarm_val),
    .osc_en(osc_en), .load(load), .load_val(load_val), .clr_wr(clr_wr),
    .unmask_wr(unmask_wr), .mask_wr(mask_wr), .wbits(wbits)
  );

  secrtc_divider u_div (
    .clk(clk), .rst_n(rst_n), .run(osc_en), .restart(load), .trim(trim),
    .tick_o(tick), .wrap_o(sec_step)
  );

  secrtc_timekeep u_time (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .step(sec_step), .alarm_val(alarm_val), .secs_o(secs),
    .alarm_evt_o(alarm_evt)
  );

  assign evt[SRC_SEC]   = sec_step;
  assign evt[SRC_ALARM] = alarm_evt;

  secrtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_wr(clr_wr),
    .unmask_wr(unmask_wr), .mask_wr(mask_wr), .wbits(wbits),
    .status_o(status), .mask_o(mask), .irq_o(irq_vec)
  );

  assign irq_sec   = irq_vec[SRC_SEC];
  assign irq_alarm = irq_vec[SRC_ALARM];

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && wbits[SRC_SEC]) |=> !irq_sec);
endmodule

// File: tb/secrtc_top_tb_top.sv
module secrtc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_sec, irq_alarm;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  secrtc_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h0C, d); check("R1 calib", d, 32'h198233);
    rd(8'h24, d); check("R1 mask", d, 32'h3);
    rd(8'h20, d); check("R1 status", d, 32'h0);
    rd(8'h40, d); check("R1 ctrl", d, 32'h0100_0000);
    rd(8'h10, d); check("R1 secs", d, 32'h0);
    check("R1 irqs", {30'h0, irq_alarm, irq_sec}, 32'h0);
  endtask

  task automatic t_calib;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R10 masked readback", d, 32'h001F_FFFF);
    wr(8'h08, 32'h0000_0004);
    rd(8'h0C, d); check("R10 readback", d, 32'h4);
  endtask

  task automatic t_plain_period;
    logic [31:0] d;
    wr(8'h00, 32'd100);              // edge E, now at E+0.5
    rd(8'h14, d); check("R2 tick zeroed", d, 32'h0);
    rd(8'h04, d); check("R2 echo", d, 32'd100);
    cyc(2); rd(8'h14, d); check("R3 tick live", d, 32'd2);
    cyc(2); rd(8'h10, d); check("R3 before step", d, 32'd100);
    rd(8'h14, d); check("R3 tick at limit", d, 32'd4);
    cyc(1); rd(8'h10, d); check("R3 step", d, 32'd101);
    rd(8'h14, d); check("R3 tick wrap", d, 32'h0);
  endtask

  task automatic t_fraction;
    logic [31:0] d;
    wr(8'h08, 32'h0013_0004);        // trim on, F=3, L=4
    wr(8'h00, 32'd0);
    cyc(5);  rd(8'h10, d); check("R4 stretched first", d, 32'd0);
    cyc(1);  rd(8'h10, d); check("R4 first step", d, 32'd1);
    cyc(76); rd(8'h10, d); check("R4 window-1", d, 32'd15);
    cyc(1);  rd(8'h10, d); check("R4 window", d, 32'd16);
    cyc(5);  rd(8'h10, d); check("R4 next stretched", d, 32'd16);
    cyc(1);  rd(8'h10, d); check("R4 next step", d, 32'd17);
    wr(8'h08, 32'h0003_0004);        // trim off, F=3 ignored
    wr(8'h00, 32'd0);
    cyc(79); rd(8'h10, d); check("R4 disabled-1", d, 32'd15);
    cyc(1);  rd(8'h10, d); check("R4 disabled", d, 32'd16);
    wr(8'h08, 32'h0000_0004);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    cyc(4); rd(8'h10, d); check("R5 max", d, 32'hFFFF_FFFF);
    cyc(1); rd(8'h10, d); check("R5 wrap", d, 32'h0);
  endtask

  task automatic t_osc;
    logic [31:0] s0, t0, d;
    wr(8'h40, 32'h0);
    rd(8'h10, s0); rd(8'h14, t0);
    cyc(20);
    rd(8'h10, d); check("R9 secs hold", d, s0);
    rd(8'h14, d); check("R9 tick hold", d, t0);
    rd(8'h40, d); check("R9 ctrl off", d, 32'h0);
    wr(8'h40, 32'h0100_0000);
    cyc(12);
    rd(8'h10, d); check("R9 runs again", {31'h0, d != s0}, 32'h1);
  endtask

  task automatic t_sec_irq;
    logic [31:0] d;
    wr(8'h18, 32'hDEAD_0000);
    wr(8'h40, 32'h0);
    wr(8'h20, 32'h3);
    rd(8'h20, d); check("R6 cleared", d & 32'h1, 32'h0);
    wr(8'h40, 32'h0100_0000);
    cyc(6);
    wr(8'h40, 32'h0);
    rd(8'h20, d); check("R6 set", d & 32'h1, 32'h1);
    check("R8 masked", {31'h0, irq_sec}, 32'h0);
    wr(8'h20, 32'h0);
    rd(8'h20, d); check("R6 write0 ignored", d & 32'h1, 32'h1);
    wr(8'h28, 32'h1);
    rd(8'h24, d); check("R8 unmask", d, 32'h2);
    check("R8 irq on", {31'h0, irq_sec}, 32'h1);
    wr(8'h2C, 32'h1);
    rd(8'h24, d); check("R8 remask", d, 32'h3);
    check("R8 irq off", {31'h0, irq_sec}, 32'h0);
    wr(8'h28, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, d); check("R6 w1c", d & 32'h1, 32'h0);
    check("R6 irq drop", {31'h0, irq_sec}, 32'h0);
    wr(8'h2C, 32'h1);
    wr(8'h40, 32'h0100_0000);
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    wr(8'h18, 32'd50);
    wr(8'h28, 32'h2);
    wr(8'h20, 32'h3);
    wr(8'h00, 32'd48);               // edge E
    cyc(10); rd(8'h10, d); check("R7 secs reach", d, 32'd50);
    rd(8'h20, d); check("R7 not yet", d & 32'h2, 32'h0);
    check("R7 irq low", {31'h0, irq_alarm}, 32'h0);
    cyc(1); rd(8'h20, d); check("R7 flag", d & 32'h2, 32'h2);
    check("R8 alarm irq", {31'h0, irq_alarm}, 32'h1);
    wr(8'h20, 32'h2);
    cyc(1); rd(8'h20, d); check("R7 no refire", d & 32'h2, 32'h0);
    check("R7 irq cleared", {31'h0, irq_alarm}, 32'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_calib();
    t_plain_period();
    t_fraction();
    t_wrap();
    t_osc();
    t_sec_irq();
    t_alarm();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule